// File: doc/BRIEF.md
# PCM Packing Output FIFO

This block sits at the end of a digital audio capture path. It takes 16-bit PCM samples and packs them into 32-bit words. It can take them from a single channel or from a channel pair. The words go into a 16-entry first-in first-out store, and software drains that store one word per pop strobe. A live data-available status is raised whenever the number of stored words reaches a programmable 4-bit threshold. A sticky overflow flag records any word that arrived while the store had no room. Each condition has an interrupt enable, and the two enabled conditions are merged onto one interrupt line.

In single-channel mode, two consecutive samples make one word. The older sample goes in the upper half. In two-channel mode, each sample strobe carries a pair. Channel 1 goes in the upper half and channel 0 in the lower half. A store enable gates incoming samples. A self-clearing soft-reset bit empties the store, drops any half-built word and clears the overflow flag.

Top module: `pcm_pack_fifo`

## Requirements
- R1: After reset the level is 0, the read data is 0, and the overflow flag, the soft-reset bit and the interrupt are all 0.
- R2: The store holds up to 16 words and returns them oldest first. The read data shows the oldest word, or 0 when the store is empty. The level counts stored words. A pop on an empty store changes nothing.
- R3: With stereo_i = 0, every second accepted sample completes a word. Bits [31:16] of that word hold the earlier sample and bits [15:0] hold the later one, and both samples come from ch0_i.
- R4: With stereo_i = 1, every accepted strobe stores one word, with ch1_i in bits [31:16] and ch0_i in bits [15:0].
- R5: avail_o is 1 exactly when the level is greater than or equal to thresh_i. It follows the level and the threshold with no storage, so a threshold of 0 keeps it at 1.
- R6: A word that completes while the store holds 16 words, with no pop in the same cycle, is dropped, and the stored words and the level stay unchanged. A pop in the same cycle makes room, and the word is stored.
- R7: A dropped word sets ovf_o, which stays at 1 until an ovf_clr_i strobe clears it. When a new drop and a clear arrive in the same cycle, the flag stays set.
- R8: irq_o equals (avail_o AND avail_ie_i) OR (ovf_o AND ovf_ie_i).
- R9: While fifo_en_i is 0, sample strobes are ignored and any pending half word is discarded. Pops still work.
- R10: A soft-reset request empties the store, discards the pending half word and clears ovf_o at the next clock edge. srst_bit_o then reads 1 for one cycle and returns to 0 by itself. Samples in the request cycle and in that following cycle are ignored.
- R11: Setting stereo_i to 1 discards a pending single-channel half word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | Store enable; 0 ignores samples and drops the half word |
| stereo_i | input | 1 | 1 = two-channel packing, 0 = single-channel packing |
| srst_req_i | input | 1 | Soft-reset request strobe |
| smp_vld_i | input | 1 | Sample strobe |
| ch0_i | input | 16 | Channel 0 sample, and the only sample in single-channel mode |
| ch1_i | input | 16 | Channel 1 sample |
| thresh_i | input | 4 | Data-available threshold |
| avail_ie_i | input | 1 | Data-available interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_clr_i | input | 1 | Overflow clear strobe (write-one-to-clear) |
| pop_i | input | 1 | Pop the oldest word |
| rd_data_o | output | 32 | Oldest stored word, 0 when empty |
| level_o | output | 5 | Number of stored words |
| avail_o | output | 1 | Level is at or above the threshold |
| ovf_o | output | 1 | Sticky overflow flag |
| srst_bit_o | output | 1 | Soft-reset bit readback, self-clearing |
| irq_o | output | 1 | Combined interrupt |

## Verification
Single-channel runs use sample values that grow by a fixed step. A swapped half or a lost pairing phase therefore shows up as a wrong word rather than a plausible one. Two-channel runs use different arithmetic series on the two channels, so that a channel swap can be told apart from a half swap. The threshold is swept over all sixteen values at every level from 0 to 16, with both interrupt enables. This separates a greater-or-equal compare from a strict one and catches off-by-one level counts. Overflow is driven with and without a simultaneous pop, with a simultaneous clear, and around disable, soft reset and mode switches with a half word pending.

// File: rtl/pcm_pack_pkg.sv
package pcm_pack_pkg;

  typedef enum logic {
    MODE_MONO   = 1'b0,
    MODE_STEREO = 1'b1
  } chan_mode_e;

  typedef struct packed {
    logic full;
    logic empty;
  } fifo_stat_t;

endpackage

// File: rtl/pcm_packer.sv
module pcm_packer
  import pcm_pack_pkg::*;
#(
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned WORD_W = 2 * SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              flush_i,
  input  chan_mode_e        mode_i,
  input  logic              smp_vld_i,
  input  logic [SMP_W-1:0]  ch0_i,
  input  logic [SMP_W-1:0]  ch1_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);

  logic             half_vld_q, half_vld_d;
  logic [SMP_W-1:0] half_q;
  logic             half_ld;

  // next-state
  always_comb begin
    half_vld_d = half_vld_q;
    half_ld    = 1'b0;
    push_o     = 1'b0;
    word_o     = {ch1_i, ch0_i};
    if (flush_i || !accept_i) begin
      half_vld_d = 1'b0;
    end else if (mode_i == MODE_STEREO) begin
      half_vld_d = 1'b0;
      push_o     = smp_vld_i;
    end else if (smp_vld_i) begin
      if (half_vld_q) begin
        push_o     = 1'b1;
        word_o     = {half_q, ch0_i};
        half_vld_d = 1'b0;
      end else begin
        half_ld    = 1'b1;
        half_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_vld_q <= 1'b0;
    else        half_vld_q <= half_vld_d;
  end

  always_ff @(posedge clk) begin
    if (half_ld) half_q <= ch0_i;
  end

  // R3: a first accepted mono sample is held for pairing
  a_r3_first_half_held: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !flush_i && mode_i == MODE_MONO && smp_vld_i && !half_vld_q) |=> half_vld_q);

  // R9 / R10: disable or flush leaves nothing pending
  a_r9_disable_drops_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i || flush_i) |=> !half_vld_q);

  // R11: stereo mode never keeps a half word
  a_r11_stereo_no_half: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_STEREO) |=> !half_vld_q);

endmodule

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo
  import pcm_pack_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CW-1:0]     level_o,
  output logic              drop_o
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     level_q, level_d;
  fifo_stat_t        stat;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    stat.full  = (level_q == CW'(DEPTH));
    stat.empty = (level_q == '0);
    do_pop     = pop_i && !stat.empty && !clear_i;
    do_push    = push_i && !clear_i && (!stat.full || do_pop);
    drop_o     = push_i && !clear_i && stat.full && !do_pop;
  end

  // next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (clear_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_d = level_q + 1'b1;
        2'b01:   level_d = level_q - 1'b1;
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = stat.empty ? '0 : mem[rd_ptr_q];
  assign level_o = level_q;

  // R2: level never exceeds the depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH));

  // R2: popping an empty store changes nothing
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && stat.empty && !push_i && !clear_i) |=> (level_q == '0));

  // R6: a dropped word leaves the level unchanged
  a_r6_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> $stable(level_q));

endmodule

// File: rtl/pcm_flag_ctrl.sv
module pcm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_req_i,
  input  logic ovf_evt_i,
  input  logic ovf_clr_i,
  input  logic avail_i,
  input  logic avail_ie_i,
  input  logic ovf_ie_i,
  output logic ovf_o,
  output logic srst_bit_o,
  output logic irq_o
);

  logic ovf_q, ovf_d;
  logic srst_q, srst_d;

  // next-state: soft reset beats a new overflow, which beats a clear
  always_comb begin
    srst_d = srst_req_i;
    if (srst_req_i)     ovf_d = 1'b0;
    else if (ovf_evt_i) ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
    else                ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      srst_q <= srst_d;
    end
  end

  assign ovf_o      = ovf_q;
  assign srst_bit_o = srst_q;
  assign irq_o      = (avail_i && avail_ie_i) || (ovf_q && ovf_ie_i);

  // R7: the flag holds until cleared
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i && !srst_req_i) |=> ovf_q);

  // R7: a new drop wins over a clear in the same cycle
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_i && !srst_req_i) |=> ovf_q);

  // R10: the soft-reset bit clears itself
  a_r10_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !srst_req_i) |=> !srst_q);

endmodule

// File: rtl/pcm_pack_fifo.sv
module pcm_pack_fifo
  import pcm_pack_pkg::*;
#(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en_i,
  input  logic                       stereo_i,
  input  logic                       srst_req_i,
  input  logic                       smp_vld_i,
  input  logic [SMP_W-1:0]           ch0_i,
  input  logic [SMP_W-1:0]           ch1_i,
  input  logic [THR_W-1:0]           thresh_i,
  input  logic                       avail_ie_i,
  input  logic                       ovf_ie_i,
  input  logic                       ovf_clr_i,
  input  logic                       pop_i,
  output logic [2*SMP_W-1:0]         rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       avail_o,
  output logic                       ovf_o,
  output logic                       srst_bit_o,
  output logic                       irq_o
);

  localparam int unsigned WORD_W = 2 * SMP_W;
  localparam int unsigned CW     = $clog2(DEPTH + 1);

  logic              accept;
  logic              push;
  logic [WORD_W-1:0] word;
  logic              drop;
  logic [CW-1:0]     level;

  assign accept = fifo_en_i && !srst_req_i && !srst_bit_o;

  pcm_packer #(.SMP_W(SMP_W), .WORD_W(WORD_W)) packer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .flush_i   (srst_req_i),
    .mode_i    (chan_mode_e'(stereo_i)),
    .smp_vld_i (smp_vld_i),
    .ch0_i     (ch0_i),
    .ch1_i     (ch1_i),
    .push_o    (push),
    .word_o    (word)
  );

  pcm_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (srst_req_i),
    .push_i  (push),
    .pop_i   (pop_i),
    .wdata_i (word),
    .rdata_o (rd_data_o),
    .level_o (level),
    .drop_o  (drop)
  );

  always_comb begin
    if (CW > THR_W) avail_o = (level >= CW'(thresh_i));
    else            avail_o = (THR_W'(level) >= thresh_i);
  end

  pcm_flag_ctrl flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_req_i (srst_req_i),
    .ovf_evt_i  (drop),
    .ovf_clr_i  (ovf_clr_i),
    .avail_i    (avail_o),
    .avail_ie_i (avail_ie_i),
    .ovf_ie_i   (ovf_ie_i),
    .ovf_o      (ovf_o),
    .srst_bit_o (srst_bit_o),
    .irq_o      (irq_o)
  );

  assign level_o = level;

  // R10: in the cycle after a request the store is empty and the flag clear
  a_r10_cleared_state: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req_i |=> (level_o == '0 && !ovf_o));

  // R9: a disabled store accepts no new words
  a_r9_no_growth_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en_i && !srst_req_i) |=> (level_o <= $past(level_o)));

endmodule

// File: tb/pcm_pack_fifo_tb.sv
module pcm_pack_fifo_tb_top;

  logic        clk, rst_n;
  logic        fifo_en_i, stereo_i, srst_req_i, smp_vld_i;
  logic [15:0] ch0_i, ch1_i;
  logic [3:0]  thresh_i;
  logic        avail_ie_i, ovf_ie_i, ovf_clr_i, pop_i;
  logic [31:0] rd_data_o;
  logic [4:0]  level_o;
  logic        avail_o, ovf_o, srst_bit_o, irq_o;

  int unsigned n_run, n_fail;
  logic [31:0] q[$];
  bit          half_v, ovf_m, done;
  logic [15:0] half_s;

  pcm_pack_fifo dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] front();
    return (q.size() > 0) ? q[0] : 32'h0;
  endfunction

  task automatic chk_state(string req);
    bit av;
    av = (q.size() >= int'(thresh_i));
    chk({req, " level"}, 32'(level_o), 32'(q.size()));
    chk({req, " data"}, rd_data_o, front());
    chk({req, " ovf"}, 32'(ovf_o), 32'(ovf_m));
    chk({req, " R8 irq"}, 32'(irq_o),
        32'((av && avail_ie_i) || (ovf_m && ovf_ie_i)));
  endtask

  function automatic void m_push(logic [31:0] w);
    if (q.size() == 16) ovf_m = 1'b1;
    else q.push_back(w);
  endfunction

  task automatic send(bit st, logic [15:0] a, logic [15:0] b, string req);
    @(negedge clk);
    stereo_i = st; smp_vld_i = 1'b1; ch0_i = a; ch1_i = b;
    @(negedge clk);
    smp_vld_i = 1'b0;
    if (!fifo_en_i) half_v = 1'b0;
    else if (st) begin half_v = 1'b0; m_push({b, a}); end
    else if (half_v) begin half_v = 1'b0; m_push({half_s, a}); end
    else begin half_s = a; half_v = 1'b1; end
    chk_state(req);
  endtask

  task automatic pop1(string req);
    @(negedge clk);
    chk({req, " head"}, rd_data_o, front());
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
    chk_state(req);
  endtask

  task automatic drain(string req);
    while (q.size() > 0) pop1(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; half_v = 0; ovf_m = 0; done = 0;
    rst_n = 1'b0; fifo_en_i = 0; stereo_i = 0; srst_req_i = 0; smp_vld_i = 0;
    ch0_i = 0; ch1_i = 0; thresh_i = 4'd1; avail_ie_i = 0; ovf_ie_i = 0;
    ovf_clr_i = 0; pop_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", 32'(level_o), 0);
    chk("R1 data", rd_data_o, 0);
    chk("R1 ovf", 32'(ovf_o), 0);
    chk("R1 srst", 32'(srst_bit_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R2: pop on empty
    pop1("R2 empty pop");

    // R3 mono packing
    fifo_en_i = 1'b1;
    for (int k = 0; k < 10; k++) send(1'b0, 16'h0100 + 16'(k * 7), 16'hFFFF, "R3 mono");
    drain("R3 mono drain");

    // R4 stereo packing
    for (int k = 0; k < 6; k++)
      send(1'b1, 16'h2000 + 16'(k * 5), 16'h9000 + 16'(k * 11), "R4 stereo");
    drain("R4 stereo drain");

    // R5 / R8 threshold sweep at every level
    avail_ie_i = 1'b1;
    for (int lv = 0; lv <= 16; lv++) begin
      if (lv > 0) send(1'b1, 16'(lv), 16'(16'hA000 + lv * 3), "R2 fill");
      for (int t = 0; t < 16; t++) begin
        @(negedge clk);
        thresh_i = 4'(t);
        #1;
        chk("R5 avail", 32'(avail_o), 32'(lv >= t));
        chk("R8 irq avail", 32'(irq_o), 32'(lv >= t));
      end
    end
    avail_ie_i = 1'b0;
    thresh_i = 4'd8;

    // R6 / R7 overflow when full
    send(1'b1, 16'hDEAD, 16'hBEEF, "R6 drop");
    chk("R7 ovf set", 32'(ovf_o), 1);
    ovf_ie_i = 1'b1;
    #1 chk("R8 irq ovf", 32'(irq_o), 1);
    // R6 push with pop at full is accepted
    @(negedge clk);
    pop_i = 1'b1; smp_vld_i = 1'b1; ch0_i = 16'h1234; ch1_i = 16'h5678;
    @(negedge clk);
    pop_i = 1'b0; smp_vld_i = 1'b0;
    void'(q.pop_front()); q.push_back(32'h5678_1234);
    chk_state("R6 push+pop full");
    // R7 clear together with a new drop: set wins
    @(negedge clk);
    ovf_clr_i = 1'b1; smp_vld_i = 1'b1; ch0_i = 16'h1111; ch1_i = 16'h2222;
    @(negedge clk);
    ovf_clr_i = 1'b0; smp_vld_i = 1'b0;
    chk_state("R7 set wins");
    // R7 plain clear
    @(negedge clk); ovf_clr_i = 1'b1;
    @(negedge clk); ovf_clr_i = 1'b0; ovf_m = 1'b0;
    chk_state("R7 clear");
    ovf_ie_i = 1'b0;
    drain("R6 contents kept");

    // R9 disable drops half word and ignores samples
    send(1'b0, 16'h0AAA, 0, "R9 half");
    fifo_en_i = 1'b0; half_v = 1'b0;
    send(1'b0, 16'h0BBB, 0, "R9 ignored");
    send(1'b1, 16'h0CCC, 16'h0DDD, "R9 ignored stereo");
    fifo_en_i = 1'b1;
    send(1'b0, 16'h0111, 0, "R9 new pair");
    send(1'b0, 16'h0222, 0, "R9 new pair");
    chk("R9 word", rd_data_o, 32'h0111_0222);
    drain("R9 drain");

    // R11 stereo discards pending half
    send(1'b0, 16'h7777, 0, "R11 half");
    send(1'b1, 16'h3333, 16'h4444, "R11 stereo");
    send(1'b0, 16'h5555, 0, "R11 mono");
    send(1'b0, 16'h6666, 0, "R11 mono");
    chk("R11 first", rd_data_o, 32'h4444_3333);
    drain("R11 drain");

    // R10 soft reset
    for (int k = 0; k < 16; k++) send(1'b1, 16'(k), 16'(k + 100), "R10 fill");
    send(1'b1, 16'hEEEE, 16'hEEEE, "R10 ovf");
    send(1'b0, 16'h0F0F, 0, "R10 half");
    @(negedge clk);
    srst_req_i = 1'b1; smp_vld_i = 1'b1; ch0_i = 16'h0ABC;
    @(negedge clk);
    srst_req_i = 1'b0;
    q.delete(); ovf_m = 1'b0; half_v = 1'b0;
    chk_state("R10 cleared");
    chk("R10 srst bit high", 32'(srst_bit_o), 1);
    @(negedge clk);
    smp_vld_i = 1'b0;
    chk_state("R10 busy ignored");
    chk("R10 srst bit low", 32'(srst_bit_o), 0);
    send(1'b0, 16'h0123, 0, "R10 after");
    send(1'b0, 16'h0456, 0, "R10 after");
    chk("R10 word", rd_data_o, 32'h0123_0456);
    drain("R10 drain");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule